// File: doc/BRIEF.md
# Strap-Latched Clock Mode Decoder

This block sets the operating mode of a clock generator from three select bits. Two of them come from shared pads. The block samples those pads once, when reset is released, and keeps their levels in an internal latch. After that it turns the pads around so they can drive buffered reference clocks. The third bit, a live speed select, is never latched. It takes part in the decode every cycle, so software or board logic can switch between a pair of frequencies while the chip runs.

The three bits form a code with eight values. Six of them pick a CPU/bus frequency pair. One picks a production test mode, in which every clock group runs from a fixed division of the reference. The last one floats every clock output group. For each output group (CPU and SDRAM, bus, 48 MHz, 24 MHz, and reference/IOAPIC) the block reports which source or divider to use. It also reports the nominal frequencies in tenths of a MHz and whether the bus clock is CPU/2.5 rather than CPU/2.

Top module: `fsel_strap_decoder`

## Requirements
- R1: While `rst_n` is low, `strap_pad_oe` is 0 and `strap_valid` is 0. Every group source reads 4 (high impedance). `test_mode` and `float_mode` are 0, and both frequency outputs are 0.
- R2: On the first rising clock edge with `rst_n` high, `strap_pad_in` is captured and `strap_valid` goes to 1. Each bit of `strap_pad_oe` goes to 1 on the next rising edge.
- R3: After capture, changes on `strap_pad_in` have no effect. `mode_code[2:1]` keeps the captured levels until the next reset.
- R4: `mode_code` is {captured pad bit 1, captured pad bit 0, `speed_sel`}. `speed_sel` affects the decode in the same cycle, with no register in its path.
- R5: The frequency codes give CPU/bus frequencies in tenths of a MHz: 110→600/300, 111→666/333, 100→500/250, 101→550/275, 000→750/300, 001→833/333.
- R6: `bus_frac_ratio` is 1 only for codes 000 and 001 (bus = CPU/2.5). In the other frequency codes it is 0 (bus = CPU/2).
- R7: Code 011 is test mode. `test_mode` is 1. Sources are CPU=2 (REF/2), bus=3 (REF/4), 48 MHz=2, 24 MHz=3 and reference=1 (REF). Both frequency outputs are 0.
- R8: Code 010 is tristate. `float_mode` is 1, every group source is 4 and both frequency outputs are 0.
- R9: In the six frequency codes, the CPU, bus, 48 MHz and 24 MHz groups read 0 (PLL) and the reference group reads 1. `test_mode` and `float_mode` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| strap_pad_in | input | STRAP_W | Levels seen on the shared strap pads |
| speed_sel | input | 1 | Live low select bit |
| strap_pad_oe | output | STRAP_W | Output enable for the shared pads |
| strap_valid | output | 1 | Strap levels have been captured |
| mode_code | output | STRAP_W+1 | Decoded select code |
| test_mode | output | 1 | Test mode active |
| float_mode | output | 1 | All groups high impedance |
| cpu_src | output | 3 | CPU/SDRAM group source |
| bus_src | output | 3 | Bus group source |
| f48_src | output | 3 | 48 MHz output source |
| f24_src | output | 3 | 24 MHz output source |
| ref_src | output | 3 | Reference/IOAPIC group source |
| bus_frac_ratio | output | 1 | Bus clock is CPU/2.5 |
| cpu_freq_dmhz | output | FREQ_W | CPU frequency in 0.1 MHz units |
| bus_freq_dmhz | output | FREQ_W | Bus frequency in 0.1 MHz units |

## Verification
The hardest case to reach from the ports is a strap value that goes stale. The captured bits can only change through a new reset, so every pad combination needs its own reset cycle. The stimulus therefore repeats reset with random pad levels so that all four strap pairs are covered. After each capture it keeps toggling the pads, which are now outputs, while it sweeps `speed_sel`. A latch that re-samples the pads then shows up as a wrong code.

// File: rtl/fsel_pkg.sv
// Shared types for the strap-latched clock mode decoder.
// Assumes: source codes are 3 bits and fixed across all groups.
package fsel_pkg;

    // Source selection for one clock output group
    typedef enum logic [2:0] {
        SRC_PLL  = 3'd0,
        SRC_REF1 = 3'd1,
        SRC_REF2 = 3'd2,
        SRC_REF4 = 3'd3,
        SRC_HIZ  = 3'd4
    } clk_src_e;

    // Broad operating class of a decoded code
    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_TEST  = 2'd1,
        MODE_FLOAT = 2'd2
    } mode_kind_e;

    // Sources for all five output groups
    typedef struct packed {
        clk_src_e cpu;
        clk_src_e bus;
        clk_src_e f48;
        clk_src_e f24;
        clk_src_e refc;
    } grp_src_t;

endpackage

// File: rtl/fsel_strap_latch.sv
// Captures the strap pad levels on the first clock edge after reset is released.
// Drives the pad output enables one cycle later.
// Assumes: rst_n is already synchronous to clk.
module fsel_strap_latch #(
    parameter int STRAP_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STRAP_W-1:0] pad_in,
    output logic [STRAP_W-1:0] latched,
    output logic               valid,
    output logic [STRAP_W-1:0] pad_oe
);

    // One-shot capture of the pads; frozen until the next reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latched <= '0;
            valid   <= 1'b0;
        end else if (!valid) begin
            latched <= pad_in;
            valid   <= 1'b1;
        end
    end

    // Per-pad direction turn-around, one cycle after capture
    for (genvar i = 0; i < STRAP_W; i++) begin : g_oe
        always_ff @(posedge clk) begin
            if (!rst_n) pad_oe[i] <= 1'b0;
            else        pad_oe[i] <= valid;
        end
    end

endmodule

// File: rtl/fsel_mode_decode.sv
// Maps a 3-bit select code to a mode class, nominal frequencies and the bus ratio.
// Assumes: CODE_W is 3; frequencies are in tenths of a MHz and fit in FREQ_W.
module fsel_mode_decode
    import fsel_pkg::*;
#(
    parameter int CODE_W = 3,
    parameter int FREQ_W = 10
) (
    input  logic [CODE_W-1:0] code,
    output mode_kind_e        kind,
    output logic [FREQ_W-1:0] cpu_freq,
    output logic [FREQ_W-1:0] bus_freq,
    output logic              frac_ratio
);

    // Code table: six frequency pairs, test and float
    always_comb begin
        kind       = MODE_RUN;
        cpu_freq   = '0;
        bus_freq   = '0;
        frac_ratio = 1'b0;
        case (code)
            3'b110: begin cpu_freq = FREQ_W'(600); bus_freq = FREQ_W'(300); end
            3'b111: begin cpu_freq = FREQ_W'(666); bus_freq = FREQ_W'(333); end
            3'b100: begin cpu_freq = FREQ_W'(500); bus_freq = FREQ_W'(250); end
            3'b101: begin cpu_freq = FREQ_W'(550); bus_freq = FREQ_W'(275); end
            3'b000: begin
                cpu_freq = FREQ_W'(750); bus_freq = FREQ_W'(300); frac_ratio = 1'b1;
            end
            3'b001: begin
                cpu_freq = FREQ_W'(833); bus_freq = FREQ_W'(333); frac_ratio = 1'b1;
            end
            3'b011:  kind = MODE_TEST;
            default: kind = MODE_FLOAT;
        endcase
    end

endmodule

// File: rtl/fsel_group_route.sv
// Turns the mode class into a source selection for each output group.
// Assumes: before strap capture every group is kept high impedance.
module fsel_group_route
    import fsel_pkg::*;
(
    input  logic       valid,
    input  mode_kind_e kind,
    output grp_src_t   src
);

    // Per-group source select
    always_comb begin
        src = '{cpu: SRC_HIZ, bus: SRC_HIZ, f48: SRC_HIZ, f24: SRC_HIZ, refc: SRC_HIZ};
        if (valid) begin
            case (kind)
                MODE_RUN:  src = '{cpu: SRC_PLL, bus: SRC_PLL, f48: SRC_PLL,
                                   f24: SRC_PLL, refc: SRC_REF1};
                MODE_TEST: src = '{cpu: SRC_REF2, bus: SRC_REF4, f48: SRC_REF2,
                                   f24: SRC_REF4, refc: SRC_REF1};
                default:   ;
            endcase
        end
    end

endmodule

// File: rtl/fsel_strap_decoder.sv
// Top level: strap capture, live select merge, mode decode and group routing.
// Assumes: strap pad bit 1 is the high select bit and speed_sel is the low bit.
module fsel_strap_decoder
    import fsel_pkg::*;
#(
    parameter int STRAP_W = 2,
    parameter int FREQ_W  = 10,
    localparam int CODE_W = STRAP_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STRAP_W-1:0] strap_pad_in,
    input  logic               speed_sel,
    output logic [STRAP_W-1:0] strap_pad_oe,
    output logic               strap_valid,
    output logic [CODE_W-1:0]  mode_code,
    output logic               test_mode,
    output logic               float_mode,
    output logic [2:0]         cpu_src,
    output logic [2:0]         bus_src,
    output logic [2:0]         f48_src,
    output logic [2:0]         f24_src,
    output logic [2:0]         ref_src,
    output logic               bus_frac_ratio,
    output logic [FREQ_W-1:0]  cpu_freq_dmhz,
    output logic [FREQ_W-1:0]  bus_freq_dmhz
);

    logic [STRAP_W-1:0] strap_q;
    mode_kind_e         kind;
    grp_src_t           src;
    logic [FREQ_W-1:0]  cpu_f, bus_f;
    logic               frac;

    fsel_strap_latch #(.STRAP_W(STRAP_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .pad_in(strap_pad_in),
        .latched(strap_q), .valid(strap_valid), .pad_oe(strap_pad_oe)
    );

    // Merge latched and live bits into the select code
    assign mode_code = {strap_q, speed_sel};

    fsel_mode_decode #(.CODE_W(CODE_W), .FREQ_W(FREQ_W)) u_dec (
        .code(mode_code), .kind(kind), .cpu_freq(cpu_f),
        .bus_freq(bus_f), .frac_ratio(frac)
    );

    fsel_group_route u_route (.valid(strap_valid), .kind(kind), .src(src));

    // Qualify decode results with strap validity
    always_comb begin
        test_mode      = strap_valid && (kind == MODE_TEST);
        float_mode     = strap_valid && (kind == MODE_FLOAT);
        bus_frac_ratio = strap_valid && frac;
        cpu_freq_dmhz  = strap_valid ? cpu_f : '0;
        bus_freq_dmhz  = strap_valid ? bus_f : '0;
        cpu_src        = src.cpu;
        bus_src        = src.bus;
        f48_src        = src.f48;
        f24_src        = src.f24;
        ref_src        = src.refc;
    end

endmodule

// File: rtl/fsel_strap_decoder_chk.sv
// Property checker for fsel_strap_decoder, attached by bind.
module fsel_strap_decoder_chk #(
    parameter int STRAP_W = 2,
    parameter int FREQ_W  = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic [STRAP_W-1:0] strap_pad_oe,
    input logic               strap_valid,
    input logic [STRAP_W:0]   mode_code,
    input logic               test_mode,
    input logic               float_mode,
    input logic [2:0]         cpu_src,
    input logic [2:0]         f48_src,
    input logic [2:0]         ref_src,
    input logic               bus_frac_ratio,
    input logic [FREQ_W-1:0]  cpu_freq_dmhz
);

    // R1
    invalid_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strap_valid |-> (cpu_src == 3'd4 && ref_src == 3'd4));

    // R2
    oe_follows_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strap_valid) |=> (strap_pad_oe == '1));

    // R2
    oe_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strap_pad_oe != '0) |-> strap_valid);

    // R3
    strap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strap_valid && $past(strap_valid)) |-> $stable(mode_code[STRAP_W:1]));

    // R6
    frac_fast_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_frac_ratio |-> (cpu_freq_dmhz >= FREQ_W'(750)));

    // R8
    float_all_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        float_mode |-> (f48_src == 3'd4 && !test_mode));

    // R7
    test_no_freq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode |-> (cpu_freq_dmhz == '0 && ref_src == 3'd1));

endmodule

bind fsel_strap_decoder fsel_strap_decoder_chk #(.STRAP_W(STRAP_W), .FREQ_W(FREQ_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .strap_pad_oe(strap_pad_oe), .strap_valid(strap_valid),
    .mode_code(mode_code), .test_mode(test_mode), .float_mode(float_mode),
    .cpu_src(cpu_src), .f48_src(f48_src), .ref_src(ref_src),
    .bus_frac_ratio(bus_frac_ratio), .cpu_freq_dmhz(cpu_freq_dmhz)
);

// File: tb/tb_fsel_strap_decoder.sv
module tb_fsel_strap_decoder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pads = 2'b00;
    logic       sel = 1'b0;
    logic [1:0] oe;
    logic       valid, tmode, fmode, frac;
    logic [2:0] code, s_cpu, s_bus, s_48, s_24, s_ref;
    logic [9:0] fcpu, fbus;
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    fsel_strap_decoder dut (
        .clk(clk), .rst_n(rst_n), .strap_pad_in(pads), .speed_sel(sel),
        .strap_pad_oe(oe), .strap_valid(valid), .mode_code(code),
        .test_mode(tmode), .float_mode(fmode), .cpu_src(s_cpu), .bus_src(s_bus),
        .f48_src(s_48), .f24_src(s_24), .ref_src(s_ref), .bus_frac_ratio(frac),
        .cpu_freq_dmhz(fcpu), .bus_freq_dmhz(fbus)
    );

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_cpu(logic [2:0] c);
        case (c)
            3'b110: return 600; 3'b111: return 666; 3'b100: return 500;
            3'b101: return 550; 3'b000: return 750; 3'b001: return 833;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_bus(logic [2:0] c);
        case (c)
            3'b110: return 300; 3'b111: return 333; 3'b100: return 250;
            3'b101: return 275; 3'b000: return 300; 3'b001: return 333;
            default: return 0;
        endcase
    endfunction

    // {cpu,bus,f48,f24,ref}
    function automatic logic [14:0] exp_src(logic [2:0] c);
        if (c == 3'b011) return {3'd2, 3'd3, 3'd2, 3'd3, 3'd1};
        if (c == 3'b010) return {3'd4, 3'd4, 3'd4, 3'd4, 3'd4};
        return {3'd0, 3'd0, 3'd0, 3'd0, 3'd1};
    endfunction

    task automatic check_mode(logic [1:0] strap);
        logic [2:0] c;
        c = {strap, sel};
        chk("R4", "mode_code", code, c);
        chk("R3", "strap bits", code[2:1], strap);
        chk("R5", "cpu freq", fcpu, exp_cpu(c));
        chk("R5", "bus freq", fbus, exp_bus(c));
        chk("R6", "frac ratio", frac, (c == 3'b000 || c == 3'b001) ? 1 : 0);
        chk("R7", "test flag", tmode, (c == 3'b011) ? 1 : 0);
        chk("R8", "float flag", fmode, (c == 3'b010) ? 1 : 0);
        chk(c == 3'b011 ? "R7" : (c == 3'b010 ? "R8" : "R9"), "sources",
            {s_cpu, s_bus, s_48, s_24, s_ref}, exp_src(c));
    endtask

    task automatic do_reset(logic [1:0] strap);
        @(negedge clk);
        rst_n = 1'b0;
        pads = ~strap;
        @(posedge clk); #1;
        chk("R1", "oe in reset", oe, 0);
        chk("R1", "valid in reset", valid, 0);
        chk("R1", "cpu src in reset", s_cpu, 4);
        chk("R1", "ref src in reset", s_ref, 4);
        chk("R1", "flags in reset", {tmode, fmode}, 0);
        chk("R1", "freq in reset", fcpu, 0);
        @(negedge clk);
        pads = strap;
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R2", "valid after capture edge", valid, 1);
        chk("R2", "oe at capture edge", oe, 0);
        @(negedge clk);
        pads = ~strap;
        @(posedge clk); #1;
        chk("R2", "oe one cycle later", oe, 3);
        chk("R3", "strap after pad change", code[2:1], strap);
    endtask

    initial begin
        void'($urandom(32'd5150));
        repeat (2) @(posedge clk);
        // Directed: every strap pair, both live select values
        for (int s = 0; s < 4; s++) begin
            do_reset(2'(s));
            for (int f = 0; f < 2; f++) begin
                @(negedge clk);
                sel = 1'(f);
                #1 check_mode(2'(s));
            end
        end
        // Random: resets with random straps, wiggled pads, toggled select
        for (int i = 0; i < 30; i++) begin
            logic [1:0] st;
            st = 2'($urandom_range(0, 3));
            do_reset(st);
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                sel  = 1'($urandom_range(0, 1));
                pads = 2'($urandom_range(0, 3));
                #1 check_mode(st);
                @(posedge clk); #1;
                check_mode(st);
            end
        end
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule